// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel of a general-purpose timer. It is programmed over an 8-bit register bus. The timer's counter value, its update event and an already prescaled edge event come in from outside. The channel holds a 16-bit value in two registers. The working register faces the bus and is the only one software sees. The active register is the one the channel actually uses. Software reaches the 16-bit value one byte at a time, at a high-byte address and a low-byte address.

In capture mode an input event (or a software trigger) latches the counter into the active register. The value is then copied to the working register. A capture raises the channel flag, and a capture that finds the flag already raised also raises the overrun flag. If software has read the high byte and not yet the low byte, the copy is held back until the low byte has been read. This keeps a two-byte read from being split across two captures.

In compare mode software writes the working register. The value moves into the active register either at once or only on the timer's update event. While the high byte has been written and the low byte has not, no transfer takes place. The active register is compared with the counter. A match (or a software trigger) sets the flag and drives a reference signal in one of four ways. The reference then goes through a polarity inverter and an enable gate to reach the pin.

Top module: `ccx_channel`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and the reference, pin, channel flag and overrun flag are all 0.
- R2: Address map. Address 0 is configuration, read/write, with bits [1:0] mode select, [2] preload enable, [5:3] output mode, [6] polarity and [7] output enable. Address 1 holds status, with bit 0 the channel flag and bit 1 the overrun flag. Address 2 is the trigger, where writing bit 0 = 1 fires a software event. Address 3 is the value high byte and address 4 the value low byte. Bus reads return the addressed register in the same cycle.
- R3: When mode select is nonzero (capture), an input event latches the counter into the active register, copies it to the working register in that same edge, and sets the channel flag.
- R4: A capture while the channel flag is already 1 sets the overrun flag, including when the copy to the working register is held back by a pending read. Writing 0 to status bit 1 clears the overrun flag, and writing 1 there has no effect.
- R5: Reading the high byte opens a read lock, and reading the low byte closes it. While the lock is open, no capture alters the working register. A capture held back in this way is copied one cycle after the lock closes. Reading the low byte clears the channel flag.
- R6: When mode select is 0 (compare), the active register is compared with the counter, giving an equal output and a greater-than output. When preload is disabled, the active register takes the working value on every edge at which no write lock is open.
- R7: When preload is enabled, the active register takes the working value only on an edge that has the update event.
- R8: Writing the high byte opens a write lock, and writing the low byte closes it. While the lock is open, no transfer to the active register takes place, even on an update event.
- R9: Output mode values: 0 holds the reference, 1 sets it on a match, 2 clears it on a match, 3 inverts it on a match. Values 4 to 7 hold it as well.
- R10: The pin equals the reference XOR polarity when output enable is 1, and 0 when output enable is 0.
- R11: The software trigger acts as a capture event in capture mode and as a match in compare mode.
- R12: A compare match sets the channel flag. Writing 0 to status bit 0 clears it.
- R13: In capture mode, bus writes to the value bytes are ignored and do not open the write lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | 16 | Running counter value from the time base |
| uev_i | input | 1 | Update event from the time base |
| cap_evt_i | input | 1 | Prescaled input edge event |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| ccif_o | output | 1 | Channel capture/compare flag |
| ccof_o | output | 1 | Overrun flag |
| cmp_eq_o | output | 1 | Counter equals the active register |
| cmp_gt_o | output | 1 | Counter greater than the active register |
| oref_o | output | 1 | Reference signal |
| pin_o | output | 1 | Channel output after polarity and enable |

## Verification
A capture event can land on the same edge as the read of the low byte that closes an open read lock. The bench provokes this by reading the high byte, firing a capture while the lock is open, and then reading the low byte. That read must still return the old byte. The new value must appear one cycle later, and the overrun flag must rise because the channel flag was already set. In compare mode the bench also sends an update event while a write lock is open, and judges through the equal output on later counter values that no transfer took place. A behavioural model updated on every clock checks the flags, reference, pin and comparison outputs.

// File: rtl/ccx_pkg.sv
// Shared definitions for the capture/compare channel: register addresses,
// the configuration layout and the output-mode encoding.
package ccx_pkg;

    localparam int ADR_CFG  = 0;
    localparam int ADR_STAT = 1;
    localparam int ADR_GEN  = 2;
    localparam int ADR_VLO  = 4;   // low value byte; higher bytes sit below it

    typedef enum logic [2:0] {
        OM_FROZEN = 3'd0,
        OM_SET    = 3'd1,
        OM_CLR    = 3'd2,
        OM_TOG    = 3'd3
    } omode_e;

    typedef struct packed {
        logic       oe;    // [7] output enable
        logic       pol;   // [6] output polarity
        logic [2:0] om;    // [5:3] output mode
        logic       pe;    // [2] compare preload enable
        logic [1:0] sel;   // [1:0] 0 = compare, nonzero = capture
    } cfg_t;

endpackage

// File: rtl/ccx_busif.sv
// Register bus front end. Holds the configuration register, decodes the
// byte strobes and keeps the read and write locks of the two-byte value.
// Assumes read and write strobes are never active together and BW >= 8.
module ccx_busif
    import ccx_pkg::*;
#(
    parameter int BW = 8,
    parameter int AW = 3,
    parameter int NB = 2
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [BW-1:0] wdata_i,
    output cfg_t          cfg_o,
    output logic          cap_mode_o,
    output logic [NB-1:0] wr_lane_o,
    output logic          rd_lo_o,
    output logic          gen_o,
    output logic          clr_if_o,
    output logic          clr_of_o,
    output logic          rd_lock_o,
    output logic          wr_lock_o
);
    localparam int ADR_VHI = ADR_VLO - (NB - 1);

    cfg_t cfg_q;
    logic rd_lock_q, wr_lock_q;
    logic rd_hi, st_wr;

    assign cap_mode_o = |cfg_q.sel;
    assign cfg_o      = cfg_q;

    // Byte-lane write strobes; value bytes are writable only in compare mode.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign wr_lane_o[g] = wr_en_i && !cap_mode_o && (addr_i == AW'(ADR_VLO - g));
    end

    assign rd_hi    = rd_en_i && (addr_i == AW'(ADR_VHI));
    assign rd_lo_o  = rd_en_i && (addr_i == AW'(ADR_VLO));
    assign st_wr    = wr_en_i && (addr_i == AW'(ADR_STAT));
    assign clr_if_o = st_wr && !wdata_i[0];
    assign clr_of_o = st_wr && !wdata_i[1];
    assign gen_o    = wr_en_i && (addr_i == AW'(ADR_GEN)) && wdata_i[0];

    // Configuration register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en_i && (addr_i == AW'(ADR_CFG))) begin
            cfg_q <= cfg_t'(wdata_i[7:0]);
        end
    end

    // Read lock: opened by the high-byte read, closed by the low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_lock_q <= 1'b0;
        else if (rd_hi)   rd_lock_q <= 1'b1;
        else if (rd_lo_o) rd_lock_q <= 1'b0;
    end

    // Write lock: opened by the high-byte write, closed by the low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)                wr_lock_q <= 1'b0;
        else if (wr_lane_o[NB-1])  wr_lock_q <= 1'b1;
        else if (wr_lane_o[0])     wr_lock_q <= 1'b0;
    end

    assign rd_lock_o = rd_lock_q;
    assign wr_lock_o = wr_lock_q;

    // R13: no value write may open the write lock in capture mode
    p_no_wlock_capture_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode_o && !wr_lock_o |=> !wr_lock_o || !$past(cap_mode_o) || $past(wr_en_i && addr_i == AW'(ADR_CFG)));

endmodule

// File: rtl/ccx_store.sv
// Working and active value registers with the capture and compare
// transfers, the held-back capture copy, the comparator and both flags.
// Assumes the lock and strobe inputs come from ccx_busif.
module ccx_store #(
    parameter int CW = 16,
    parameter int BW = 8,
    parameter int NB = 2
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          cap_mode_i,
    input  logic          pe_i,
    input  logic          uev_i,
    input  logic          cap_evt_i,
    input  logic          gen_i,
    input  logic [NB-1:0] wr_lane_i,
    input  logic [BW-1:0] wdata_i,
    input  logic          rd_lock_i,
    input  logic          wr_lock_i,
    input  logic          rd_lo_i,
    input  logic          clr_if_i,
    input  logic          clr_of_i,
    output logic [CW-1:0] pre_o,
    output logic          eq_o,
    output logic          gt_o,
    output logic          match_o,
    output logic          ccif_o,
    output logic          ccof_o
);
    logic [CW-1:0] pre_q, pre_d, sh_q, sh_d;
    logic          pd_q, pd_d;
    logic          ccif_q, ccif_d, ccof_q, ccof_d;
    logic          cap_hit;

    assign eq_o    = (cnt_i == sh_q);
    assign gt_o    = (cnt_i >  sh_q);
    assign cap_hit = cap_mode_i && (cap_evt_i || gen_i);
    assign match_o = !cap_mode_i && (eq_o || gen_i);

    // Next value of the working and active registers and the held-back copy.
    always_comb begin
        pre_d = pre_q;
        sh_d  = sh_q;
        pd_d  = pd_q;
        if (cap_mode_i) begin
            if (cap_hit) begin
                sh_d = cnt_i;
                if (!rd_lock_i) pre_d = cnt_i;
                pd_d = rd_lock_i;
            end else if (pd_q && !rd_lock_i) begin
                pre_d = sh_q;
                pd_d  = 1'b0;
            end
        end else begin
            pd_d = 1'b0;
            for (int g = 0; g < NB; g++) begin
                if (wr_lane_i[g]) pre_d[g*BW +: BW] = wdata_i;
            end
            if (!wr_lock_i && (!pe_i || uev_i)) sh_d = pre_q;
        end
    end

    // Next value of the channel and overrun flags; setting beats clearing.
    always_comb begin
        ccif_d = ccif_q;
        if (cap_hit || match_o)      ccif_d = 1'b1;
        else if (rd_lo_i || clr_if_i) ccif_d = 1'b0;
        ccof_d = ccof_q;
        if (cap_hit && ccif_q)       ccof_d = 1'b1;
        else if (clr_of_i)           ccof_d = 1'b0;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            sh_q   <= '0;
            pd_q   <= 1'b0;
            ccif_q <= 1'b0;
            ccof_q <= 1'b0;
        end else begin
            pre_q  <= pre_d;
            sh_q   <= sh_d;
            pd_q   <= pd_d;
            ccif_q <= ccif_d;
            ccof_q <= ccof_d;
        end
    end

    assign pre_o  = pre_q;
    assign ccif_o = ccif_q;
    assign ccof_o = ccof_q;

    // R5: an open read lock freezes the working register in capture mode
    p_rdlock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode_i && rd_lock_i |=> $stable(pre_q));

    // R4: overrun only rises when the channel flag was already set
    p_ovr_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ccof_q) |-> $past(ccif_q));

    // R8: an open write lock freezes the active register in compare mode
    p_wrlock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_mode_i && wr_lock_i |=> $stable(sh_q));

    // R7: with preload on, the active register waits for the update event
    p_preload_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_mode_i && pe_i && !uev_i |=> $stable(sh_q));

    // R3: a capture always leaves the channel flag set
    p_capture_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> ccif_q);

endmodule

// File: rtl/ccx_outstage.sv
// Reference generator and pin stage. Applies the output mode on each
// compare match and drives the pin through polarity and enable.
// Assumes match_i is already gated to compare mode.
module ccx_outstage
    import ccx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_i,
    input  logic [2:0] om_i,
    input  logic       pol_i,
    input  logic       oe_i,
    output logic       oref_o,
    output logic       pin_o
);
    logic ref_q;

    // Reference update on a match according to the output mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else if (match_i) begin
            case (omode_e'(om_i))
                OM_SET:  ref_q <= 1'b1;
                OM_CLR:  ref_q <= 1'b0;
                OM_TOG:  ref_q <= ~ref_q;
                default: ref_q <= ref_q;
            endcase
        end
    end

    assign oref_o = ref_q;
    assign pin_o  = oe_i & (ref_q ^ pol_i);

    // R9: toggle mode inverts the reference on every match
    p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_i && om_i == 3'd3 |=> oref_o != $past(oref_o));

    // R9: frozen mode never moves the reference
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        om_i == 3'd0 |=> $stable(oref_o));

    // R10: a disabled output drives 0
    p_pin_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |-> !pin_o);

endmodule

// File: rtl/ccx_channel.sv
// Top of one timer capture/compare channel: bus front end, value store
// and output stage, plus the read-data multiplexer.
// Assumes CW = NB * BW with NB = 2 and the counter supplied from outside.
module ccx_channel
    import ccx_pkg::*;
#(
    parameter int CW = 16,
    parameter int BW = 8,
    parameter int AW = 3
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          uev_i,
    input  logic          cap_evt_i,
    input  logic          bus_wr_i,
    input  logic          bus_rd_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [BW-1:0] bus_wdata_i,
    output logic [BW-1:0] bus_rdata_o,
    output logic          ccif_o,
    output logic          ccof_o,
    output logic          cmp_eq_o,
    output logic          cmp_gt_o,
    output logic          oref_o,
    output logic          pin_o
);
    localparam int NB = CW / BW;

    cfg_t          cfg;
    logic          cap_mode, rd_lo, gen, clr_if, clr_of, rd_lock, wr_lock, match;
    logic [NB-1:0] wr_lane;
    logic [CW-1:0] pre;

    ccx_busif #(.BW(BW), .AW(AW), .NB(NB)) u_busif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (bus_wr_i),
        .rd_en_i    (bus_rd_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .cfg_o      (cfg),
        .cap_mode_o (cap_mode),
        .wr_lane_o  (wr_lane),
        .rd_lo_o    (rd_lo),
        .gen_o      (gen),
        .clr_if_o   (clr_if),
        .clr_of_o   (clr_of),
        .rd_lock_o  (rd_lock),
        .wr_lock_o  (wr_lock)
    );

    ccx_store #(.CW(CW), .BW(BW), .NB(NB)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt_i),
        .cap_mode_i (cap_mode),
        .pe_i       (cfg.pe),
        .uev_i      (uev_i),
        .cap_evt_i  (cap_evt_i),
        .gen_i      (gen),
        .wr_lane_i  (wr_lane),
        .wdata_i    (bus_wdata_i),
        .rd_lock_i  (rd_lock),
        .wr_lock_i  (wr_lock),
        .rd_lo_i    (rd_lo),
        .clr_if_i   (clr_if),
        .clr_of_i   (clr_of),
        .pre_o      (pre),
        .eq_o       (cmp_eq_o),
        .gt_o       (cmp_gt_o),
        .match_o    (match),
        .ccif_o     (ccif_o),
        .ccof_o     (ccof_o)
    );

    ccx_outstage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .om_i    (cfg.om),
        .pol_i   (cfg.pol),
        .oe_i    (cfg.oe),
        .oref_o  (oref_o),
        .pin_o   (pin_o)
    );

    // Read-data multiplexer for the addressed register.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == AW'(ADR_CFG))  bus_rdata_o = BW'(cfg);
        if (bus_addr_i == AW'(ADR_STAT)) bus_rdata_o = BW'({ccof_o, ccif_o});
        for (int g = 0; g < NB; g++) begin
            if (bus_addr_i == AW'(ADR_VLO - g)) bus_rdata_o = pre[g*BW +: BW];
        end
    end

endmodule

// File: tb/sim_ccx_channel.sv
`timescale 1ns/1ps
module sim_ccx_channel;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] d_cnt;
    logic        d_uev, d_cap, d_wr, d_rd;
    logic [2:0]  d_addr;
    logic [7:0]  d_wd;
    logic [7:0]  rdata;
    logic        ccif, ccof, eq, gt, oref, pin;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // behavioural reference state
    logic [7:0]  m_cfg;
    logic [15:0] m_pre, m_sh;
    logic        m_rl, m_wl, m_pd, m_if, m_of, m_ref;

    always #10 clk = ~clk;

    ccx_channel u0 (
        .clk(clk), .rst_n(rst_n), .cnt_i(d_cnt), .uev_i(d_uev), .cap_evt_i(d_cap),
        .bus_wr_i(d_wr), .bus_rd_i(d_rd), .bus_addr_i(d_addr), .bus_wdata_i(d_wd),
        .bus_rdata_o(rdata), .ccif_o(ccif), .ccof_o(ccof), .cmp_eq_o(eq),
        .cmp_gt_o(gt), .oref_o(oref), .pin_o(pin)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd();
        case (d_addr)
            3'd0:    return m_cfg;
            3'd1:    return {6'd0, m_of, m_if};
            3'd3:    return m_pre[15:8];
            3'd4:    return m_pre[7:0];
            default: return 8'd0;
        endcase
    endfunction

    task automatic model_step();
        logic capm, gen, wrhi, wrlo, rdhi, rdlo, caphit, cmpev, stw;
        logic [15:0] n_pre, n_sh;
        logic n_pd, n_if, n_of, n_ref, n_rl, n_wl;
        logic [7:0] n_cfg;
        capm   = (m_cfg[1:0] != 2'd0);
        gen    = d_wr && d_addr == 3'd2 && d_wd[0];
        wrhi   = d_wr && d_addr == 3'd3 && !capm;
        wrlo   = d_wr && d_addr == 3'd4 && !capm;
        rdhi   = d_rd && d_addr == 3'd3;
        rdlo   = d_rd && d_addr == 3'd4;
        stw    = d_wr && d_addr == 3'd1;
        caphit = capm && (d_cap || gen);
        cmpev  = !capm && ((d_cnt == m_sh) || gen);
        n_cfg = (d_wr && d_addr == 3'd0) ? d_wd : m_cfg;
        n_rl  = rdhi ? 1'b1 : (rdlo ? 1'b0 : m_rl);
        n_wl  = wrhi ? 1'b1 : (wrlo ? 1'b0 : m_wl);
        n_pre = m_pre; n_sh = m_sh; n_pd = m_pd;
        if (capm) begin
            if (caphit) begin
                n_sh = d_cnt;
                if (!m_rl) n_pre = d_cnt;
                n_pd = m_rl;
            end else if (m_pd && !m_rl) begin
                n_pre = m_sh;
                n_pd  = 1'b0;
            end
        end else begin
            n_pd = 1'b0;
            if (wrhi) n_pre[15:8] = d_wd;
            if (wrlo) n_pre[7:0]  = d_wd;
            if (!m_wl && (!m_cfg[2] || d_uev)) n_sh = m_pre;
        end
        if (caphit || cmpev) n_if = 1'b1;
        else if (rdlo || (stw && !d_wd[0])) n_if = 1'b0;
        else n_if = m_if;
        if (caphit && m_if) n_of = 1'b1;
        else if (stw && !d_wd[1]) n_of = 1'b0;
        else n_of = m_of;
        n_ref = m_ref;
        if (cmpev) begin
            if (m_cfg[5:3] == 3'd1) n_ref = 1'b1;
            else if (m_cfg[5:3] == 3'd2) n_ref = 1'b0;
            else if (m_cfg[5:3] == 3'd3) n_ref = ~m_ref;
        end
        m_cfg = n_cfg; m_pre = n_pre; m_sh = n_sh; m_pd = n_pd; m_rl = n_rl;
        m_wl = n_wl; m_if = n_if; m_of = n_of; m_ref = n_ref;
    endtask

    // One clock: check read data before the edge, advance the model, compare after it.
    task automatic tick();
        #2;
        if (d_rd) chk("R2 readback vs model", rdata, model_rd());
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R9 oref vs model", oref, m_ref);
        chk("R10 pin vs model", pin, m_cfg[7] & (m_ref ^ m_cfg[6]));
        chk("R3 R12 ccif vs model", ccif, m_if);
        chk("R4 ccof vs model", ccof, m_of);
        chk("R6 eq vs model", eq, d_cnt == m_sh);
        chk("R6 gt vs model", gt, d_cnt > m_sh);
        d_wr = 0; d_rd = 0; d_uev = 0; d_cap = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        d_wr = 1; d_addr = a; d_wd = v;
        tick();
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        d_rd = 1; d_addr = a;
        #1;
        chk(tag, rdata, exp);
        tick();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; d_cnt = 16'h8000; d_uev = 0; d_cap = 0; d_wr = 0; d_rd = 0;
        d_addr = 0; d_wd = 0;
        m_cfg = 0; m_pre = 0; m_sh = 0; m_rl = 0; m_wl = 0; m_pd = 0;
        m_if = 0; m_of = 0; m_ref = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 pin", pin, 0); chk("R1 oref", oref, 0);
        chk("R1 ccif", ccif, 0); chk("R1 ccof", ccof, 0);
        rd(3'd0, 8'h00, "R1 cfg"); rd(3'd1, 8'h00, "R1 status");
        rd(3'd3, 8'h00, "R1 value hi"); rd(3'd4, 8'h00, "R1 value lo");

        // R6 R9 R12: compare, no preload, set on match
        wr(3'd0, 8'h88);
        rd(3'd0, 8'h88, "R2 cfg readback");
        wr(3'd3, 8'h12); wr(3'd4, 8'h34); tick();
        d_cnt = 16'h1233; tick();
        chk("R9 before match", oref, 0); chk("R6 gt below", gt, 0);
        d_cnt = 16'h1234; tick();
        chk("R9 set on match", oref, 1); chk("R12 flag on match", ccif, 1);
        chk("R6 eq", eq, 1);
        d_cnt = 16'h1235; tick();
        chk("R6 gt above", gt, 1); chk("R9 set holds", oref, 1);
        wr(3'd1, 8'h00);
        chk("R12 flag cleared", ccif, 0);

        // R9 R10: toggle with inverted polarity, then disable
        wr(3'd0, 8'hD8);
        d_cnt = 16'h1234; tick();
        chk("R9 toggle", oref, 0); chk("R10 inverted pin", pin, 1);
        d_cnt = 16'h1235; tick();
        wr(3'd0, 8'h58);
        chk("R10 disabled pin", pin, 0);

        // R7: preload waits for the update event
        d_cnt = 16'h8000;
        wr(3'd0, 8'h8C);
        wr(3'd3, 8'h00); wr(3'd4, 8'h50); tick();
        d_cnt = 16'h0050; tick();
        chk("R7 no transfer yet", eq, 0); chk("R7 ref unchanged", oref, 0);
        d_cnt = 16'h8000; d_uev = 1; tick();
        d_cnt = 16'h0050; tick();
        chk("R7 after update", eq, 1); chk("R7 ref set", oref, 1);

        // R8: update event during an open write lock is ignored
        d_cnt = 16'h8000;
        wr(3'd0, 8'h94);
        wr(3'd3, 8'h01);
        d_uev = 1; tick();
        d_cnt = 16'h0050; tick();
        chk("R8 lock blocked transfer", eq, 1); chk("R9 clear on match", oref, 0);
        d_cnt = 16'h8000;
        wr(3'd4, 8'h60);
        d_uev = 1; tick();
        d_cnt = 16'h0160; tick();
        chk("R8 transfer after low write", eq, 1);

        // R13 R3: capture mode
        d_cnt = 16'h8000;
        wr(3'd0, 8'h01);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'hAA); wr(3'd4, 8'hBB);
        rd(3'd3, 8'h01, "R13 hi write ignored"); rd(3'd4, 8'h60, "R13 lo write ignored");
        d_cnt = 16'h4321; d_cap = 1; tick();
        chk("R3 flag on capture", ccif, 1);
        rd(3'd3, 8'h43, "R3 capture hi"); rd(3'd4, 8'h21, "R3 capture lo");
        chk("R5 low read clears flag", ccif, 0);

        // R4: overrun set and cleared
        d_cnt = 16'h1111; d_cap = 1; tick();
        chk("R4 no overrun first", ccof, 0);
        d_cnt = 16'h2222; d_cap = 1; tick();
        chk("R4 overrun", ccof, 1);
        wr(3'd1, 8'h01);
        chk("R4 overrun cleared", ccof, 0); chk("R4 flag kept", ccif, 1);

        // R5: capture during an open read lock
        rd(3'd3, 8'h22, "R5 hi before lock capture");
        d_cnt = 16'h3333; d_cap = 1; tick();
        chk("R4 overrun while blocked", ccof, 1);
        rd(3'd4, 8'h22, "R5 lo not torn");
        tick();
        rd(3'd3, 8'h33, "R5 held copy hi"); rd(3'd4, 8'h33, "R5 held copy lo");

        // R11: software trigger in both modes
        d_cnt = 16'h5555;
        wr(3'd2, 8'h01);
        rd(3'd3, 8'h55, "R11 sw capture hi"); rd(3'd4, 8'h55, "R11 sw capture lo");
        d_cnt = 16'h8000;
        wr(3'd0, 8'h98);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h01);
        chk("R11 sw match toggles", oref, 1); chk("R11 sw match flag", ccif, 1);
        wr(3'd2, 8'h01);
        chk("R11 second toggle", oref, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule